// File: doc/BRIEF.md
# Dual OS timer with timestamp counter

This peripheral supplies an operating system with its time base. A 32-bit timestamp counter counts up on every clock and never stops. Two down-counting timers each raise a sticky pending flag when they expire. A timer either reloads itself and runs again (periodic) or stops at zero (one-shot). Software reaches all of it through single-cycle word accesses on a simple 32-bit read/write bus with byte offsets.

Each timer has a control word. Its bit 0 enables the timer and its bit 1 selects one-shot mode. Bits [31:2] of the same word give the reload value, whose two low bits count as zero. The pending flags sit together in one status word. Each flag is cleared by writing a 1 to its bit, and each timer's interrupt line follows its own flag.

Top module: `ostimer`

## Requirements
- R1: After reset every timer count, every control word and the status word read 0, and both interrupt outputs are low.
- R2: The timestamp word (offset 0x00) increases by one on every clock. A bus write to it loads the written value on the write edge, and counting continues from that value.
- R3: When the timestamp counts from 0xFFFFFFFF to 0, status bit 2 becomes 1.
- R4: A write to a timer's control word (timer 1 at 0x08, timer 2 at 0x10) stores the whole word, which reads back unchanged. If bit 0 of the written word is 1, the count is loaded with the written value with bits [1:0] cleared, and a later such write restarts the count from its own value.
- R5: An enabled timer's count (timer 1 at 0x04, timer 2 at 0x0C) decreases by one per clock. A timer whose control bit 0 is 0 holds its count, and a control write with bit 0 = 0 leaves the count unchanged.
- R6: In periodic mode (bit 1 = 0), the edge that takes the count from 1 to 0 also sets the timer's status bit (timer 1 bit 0, timer 2 bit 1). On the next clock the count reloads from control bits [31:2] with bits [1:0] zero.
- R7: In one-shot mode (bit 1 = 1), the timer sets its status bit once when it reaches 0 and then stays at 0.
- R8: Writing the status word (0x20) clears each bit written as 1 and leaves each bit written as 0 unchanged. A set event on the same edge as a clear leaves the bit set. Status bits 3 and 4 always read 0.
- R9: Interrupt output bit i is equal to timer i+1's status bit. It stays high until software clears that bit.
- R10: A read at an offset that is not mapped returns 0, and a write there changes no register.
- R11: A write to a timer's count word loads that count directly.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Timer clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busSel | input | 1 | Access strobe, one cycle per access |
| busWr | input | 1 | 1 = write, 0 = read |
| busAddr | input | 8 | Byte offset of the word |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data, combinational during a read |
| irqTmr | output | 2 | Level interrupts, bit 0 timer 1, bit 1 timer 2 |

## Verification
Read data is combinational, so each read is sampled in the same cycle it is driven, before the clock edge. Every register write takes effect on the edge it is presented, and the bench counts edges from there. A control write with the enable bit set shows its reload value at the next sample point. After that the count is lower by k after k more edges. A periodic timer sets its pending flag and interrupt on the edge that takes the count to 0, and the count reloads one edge later. The bench steps every access to exactly one clock edge and adds explicit idle edges, so each expected value is placed at a known edge count. The same-edge set and clear case is lined up by issuing the status write on the edge that brings the count from 1 to 0.

// File: rtl/ostimer_pkg.sv
package ostimer_pkg;
  localparam int NUM_TMR    = 2;
  localparam int DATA_W     = 32;
  localparam int ADDR_W     = 8;
  localparam int IDX_W      = (NUM_TMR > 1) ? $clog2(NUM_TMR) : 1;
  localparam int STS_LIVE   = NUM_TMR + 1;   // timer flags + timestamp flag
  localparam int TS_OFF     = 'h00;
  localparam int TMR_BASE   = 'h04;
  localparam int TMR_STRIDE = 'h08;
  localparam int STS_OFF    = 'h20;

  typedef enum logic [2:0] {
    RD_NONE,
    RD_TS,
    RD_CNT,
    RD_CTL,
    RD_STS
  } rdKind_e;

  typedef struct packed {
    logic               wrTs;
    logic [NUM_TMR-1:0] wrCnt;
    logic [NUM_TMR-1:0] wrCtl;
    logic               wrSts;
    rdKind_e            rdKind;
    logic [IDX_W-1:0]   rdIdx;
  } strobe_t;
endpackage

// File: rtl/ostimer_ctrl.sv
module ostimer_ctrl
  import ostimer_pkg::*;
(
  input  logic              busSel,
  input  logic              busWr,
  input  logic [ADDR_W-1:0] busAddr,
  output strobe_t           stb
);
  always_comb begin
    stb = '0;
    stb.rdKind = RD_NONE;
    if (busSel) begin
      if (busAddr == ADDR_W'(TS_OFF)) begin
        stb.wrTs = busWr;
        if (!busWr) stb.rdKind = RD_TS;
      end
      if (busAddr == ADDR_W'(STS_OFF)) begin
        stb.wrSts = busWr;
        if (!busWr) stb.rdKind = RD_STS;
      end
      for (int i = 0; i < NUM_TMR; i++) begin
        if (busAddr == ADDR_W'(TMR_BASE + i * TMR_STRIDE)) begin
          stb.wrCnt[i] = busWr;
          if (!busWr) begin
            stb.rdKind = RD_CNT;
            stb.rdIdx  = IDX_W'(i);
          end
        end
        if (busAddr == ADDR_W'(TMR_BASE + i * TMR_STRIDE + 4)) begin
          stb.wrCtl[i] = busWr;
          if (!busWr) begin
            stb.rdKind = RD_CTL;
            stb.rdIdx  = IDX_W'(i);
          end
        end
      end
    end
  end
endmodule

// File: rtl/ostimer_dp.sv
module ostimer_dp
  import ostimer_pkg::*;
(
  input  logic                            clk,
  input  logic                            rstN,
  input  strobe_t                         stb,
  input  logic [DATA_W-1:0]               busWdata,
  output logic [DATA_W-1:0]               busRdata,
  output logic [DATA_W-1:0]               tsNow,
  output logic [NUM_TMR-1:0][DATA_W-1:0]  tmrCount,
  output logic [NUM_TMR-1:0][DATA_W-1:0]  tmrCtl,
  output logic [STS_LIVE-1:0]             stsNow
);
  logic [NUM_TMR-1:0]  expire;
  logic                tsWrap;
  logic [STS_LIVE-1:0] stsSet, stsClr;

  // free-running timestamp
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)         tsNow <= '0;
    else if (stb.wrTs) tsNow <= busWdata;
    else               tsNow <= tsNow + DATA_W'(1);
  end
  assign tsWrap = !stb.wrTs && (tsNow == '1);

  // down-counting timers
  for (genvar i = 0; i < NUM_TMR; i++) begin : g_tmr
    logic              en, oneShot;
    logic [DATA_W-1:0] reloadVal;
    assign en        = tmrCtl[i][0];
    assign oneShot   = tmrCtl[i][1];
    assign reloadVal = {tmrCtl[i][DATA_W-1:2], 2'b00};
    assign expire[i] = en && !stb.wrCtl[i] && !stb.wrCnt[i] && (tmrCount[i] == DATA_W'(1));

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        tmrCtl[i]   <= '0;
        tmrCount[i] <= '0;
      end else if (stb.wrCtl[i]) begin
        tmrCtl[i] <= busWdata;
        if (busWdata[0]) tmrCount[i] <= {busWdata[DATA_W-1:2], 2'b00};
      end else if (stb.wrCnt[i]) begin
        tmrCount[i] <= busWdata;
      end else if (en) begin
        if (tmrCount[i] != '0)  tmrCount[i] <= tmrCount[i] - DATA_W'(1);
        else if (!oneShot)      tmrCount[i] <= reloadVal;
      end
    end
  end

  // sticky status, set wins over clear
  assign stsSet = {tsWrap, expire};
  assign stsClr = stb.wrSts ? busWdata[STS_LIVE-1:0] : '0;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) stsNow <= '0;
    else       stsNow <= (stsNow & ~stsClr) | stsSet;
  end

  always_comb begin
    case (stb.rdKind)
      RD_TS:   busRdata = tsNow;
      RD_CNT:  busRdata = tmrCount[stb.rdIdx];
      RD_CTL:  busRdata = tmrCtl[stb.rdIdx];
      RD_STS:  busRdata = {{(DATA_W-STS_LIVE){1'b0}}, stsNow};
      default: busRdata = '0;
    endcase
  end
endmodule

// File: rtl/ostimer.sv
module ostimer
  import ostimer_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              busSel,
  input  logic              busWr,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  output logic [NUM_TMR-1:0] irqTmr
);
  strobe_t                         stb;
  logic [DATA_W-1:0]               tsNow;
  logic [NUM_TMR-1:0][DATA_W-1:0]  tmrCount;
  logic [NUM_TMR-1:0][DATA_W-1:0]  tmrCtl;
  logic [STS_LIVE-1:0]             stsNow;

  ostimer_ctrl u_ctrl (
    .busSel (busSel),
    .busWr  (busWr),
    .busAddr(busAddr),
    .stb    (stb)
  );

  ostimer_dp u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .stb     (stb),
    .busWdata(busWdata),
    .busRdata(busRdata),
    .tsNow   (tsNow),
    .tmrCount(tmrCount),
    .tmrCtl  (tmrCtl),
    .stsNow  (stsNow)
  );

  assign irqTmr = stsNow[NUM_TMR-1:0];
endmodule

// File: rtl/ostimer_chk.sv
module ostimer_chk
  import ostimer_pkg::*;
(
  input logic                            clk,
  input logic                            rstN,
  input logic                            busSel,
  input logic                            busWr,
  input logic [ADDR_W-1:0]               busAddr,
  input logic [DATA_W-1:0]               busWdata,
  input logic [DATA_W-1:0]               busRdata,
  input logic [NUM_TMR-1:0]              irqTmr,
  input logic [DATA_W-1:0]               tsNow,
  input logic [NUM_TMR-1:0][DATA_W-1:0]  tmrCount,
  input logic [NUM_TMR-1:0][DATA_W-1:0]  tmrCtl
);
  localparam int TMR_END = TMR_BASE + NUM_TMR * TMR_STRIDE - 4;

  logic mapped, tsWrite, stsWrite;
  assign mapped = (busAddr == ADDR_W'(TS_OFF)) || (busAddr == ADDR_W'(STS_OFF)) ||
                  ((busAddr >= ADDR_W'(TMR_BASE)) && (busAddr <= ADDR_W'(TMR_END)) &&
                   (busAddr[1:0] == 2'b00));
  assign tsWrite  = busSel && busWr && (busAddr == ADDR_W'(TS_OFF));
  assign stsWrite = busSel && busWr && (busAddr == ADDR_W'(STS_OFF));

  // R2: timestamp steps by one unless written
  p_ts_step_r2: assert property (@(posedge clk) disable iff (!rstN)
    !tsWrite |=> tsNow == $past(tsNow) + DATA_W'(1));

  // R10: unmapped reads return zero
  p_unmapped_zero_r10: assert property (@(posedge clk) disable iff (!rstN)
    (busSel && !busWr && !mapped) |-> busRdata == '0);

  for (genvar i = 0; i < NUM_TMR; i++) begin : g_chk
    logic tmrWrite;
    assign tmrWrite = busSel && busWr &&
      ((busAddr == ADDR_W'(TMR_BASE + i * TMR_STRIDE)) ||
       (busAddr == ADDR_W'(TMR_BASE + i * TMR_STRIDE + 4)));

    // R9: interrupt held until cleared by a 1 write
    p_irq_hold_r9: assert property (@(posedge clk) disable iff (!rstN)
      (irqTmr[i] && !(stsWrite && busWdata[i])) |=> irqTmr[i]);

    // R7: one-shot timer stays at zero
    p_oneshot_hold_r7: assert property (@(posedge clk) disable iff (!rstN)
      (tmrCtl[i][0] && tmrCtl[i][1] && tmrCount[i] == '0 && !tmrWrite) |=> tmrCount[i] == '0);

    // R6: periodic timer reloads the cycle after reaching zero
    p_periodic_reload_r6: assert property (@(posedge clk) disable iff (!rstN)
      (tmrCtl[i][0] && !tmrCtl[i][1] && tmrCount[i] == '0 && !tmrWrite) |=>
      tmrCount[i] == {$past(tmrCtl[i][DATA_W-1:2]), 2'b00});

    // R6: count 1 -> 0 raises the interrupt on the same edge
    p_expire_irq_r6: assert property (@(posedge clk) disable iff (!rstN)
      (tmrCtl[i][0] && tmrCount[i] == DATA_W'(1) && !tmrWrite) |=> irqTmr[i]);
  end
endmodule

bind ostimer ostimer_chk u_chk (.*);

// File: tb/ostimer_tb_top.sv
module ostimer_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busSel = 1'b0;
  logic        busWr = 1'b0;
  logic [7:0]  busAddr = '0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic [1:0]  irqTmr;

  int nChecks = 0;
  int nFails  = 0;

  always #5 clk = ~clk;

  ostimer dut_i (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWr(busWr),
    .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata), .irqTmr(irqTmr)
  );

  // {isWr, addr, wdata, expected read, extra idle edges}
  localparam int NVEC = 18;
  localparam logic [80:0] VEC [NVEC] = '{
    {1'b1, 8'h08, 32'h0000_0009, 32'h0, 8'd0},  // timer1 periodic, reload 8 (R4)
    {1'b0, 8'h04, 32'h0, 32'd8, 8'd0},          // R4 loaded
    {1'b0, 8'h04, 32'h0, 32'd7, 8'd0},          // R5 decrement
    {1'b0, 8'h08, 32'h0, 32'h9, 8'd0},          // R4 readback
    {1'b0, 8'h20, 32'h0, 32'h0, 8'd3},
    {1'b0, 8'h04, 32'h0, 32'd1, 8'd0},
    {1'b0, 8'h20, 32'h0, 32'h1, 8'd0},          // R6 pending at zero
    {1'b0, 8'h04, 32'h0, 32'd8, 8'd0},          // R6 reload
    {1'b1, 8'h20, 32'h1, 32'h0, 8'd0},          // R8 clear
    {1'b0, 8'h20, 32'h0, 32'h0, 8'd0},
    {1'b1, 8'h08, 32'h0, 32'h0, 8'd0},          // disable
    {1'b0, 8'h04, 32'h0, 32'd5, 8'd2},          // R5 hold
    {1'b0, 8'h04, 32'h0, 32'd5, 8'd0},
    {1'b1, 8'h14, 32'hFFFF_FFFF, 32'h0, 8'd0},  // R10 unmapped write
    {1'b0, 8'h14, 32'h0, 32'h0, 8'd0},
    {1'b0, 8'h24, 32'h0, 32'h0, 8'd0},
    {1'b0, 8'h20, 32'h0, 32'h0, 8'd0},
    {1'b0, 8'h10, 32'h0, 32'h0, 8'd0}
  };

  task automatic finishRun();
    $display("  [TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  endtask

  task automatic doWrite(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    busSel = 1'b1; busWr = 1'b1; busAddr = a; busWdata = d;
    @(posedge clk);
    #1 busSel = 1'b0; busWr = 1'b0;
  endtask

  task automatic doRead(input logic [7:0] a, input logic [31:0] exp, input string req);
    @(negedge clk);
    busSel = 1'b1; busWr = 1'b0; busAddr = a;
    #1;
    nChecks++;
    if (busRdata !== exp) begin
      nFails++;
      $display("FAIL %s read 0x%02h: actual 0x%08h expected 0x%08h", req, a, busRdata, exp);
    end
    @(posedge clk);
    #1 busSel = 1'b0;
  endtask

  task automatic checkIrq(input logic [1:0] exp, input string req);
    @(negedge clk);
    #1;
    nChecks++;
    if (irqTmr !== exp) begin
      nFails++;
      $display("FAIL %s irqTmr: actual %b expected %b", req, irqTmr, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nChecks++;
    nFails++;
    $display("FAIL watchdog expired: actual timeout expected completion");
    finishRun();
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rstN = 1'b1;

    // R1 reset state
    checkIrq(2'b00, "R1");
    doRead(8'h04, 32'h0, "R1");
    doRead(8'h08, 32'h0, "R1");
    doRead(8'h0C, 32'h0, "R1");
    doRead(8'h10, 32'h0, "R1");
    doRead(8'h20, 32'h0, "R1");

    // vector table
    for (int k = 0; k < NVEC; k++) begin
      if (VEC[k][80]) doWrite(VEC[k][79:72], VEC[k][71:40]);
      else            doRead(VEC[k][79:72], VEC[k][39:8], $sformatf("R4/R5/R6/R8/R10 step %0d", k));
      idle(int'(VEC[k][7:0]));
    end

    // R2 load and count, R3 wrap flag
    doWrite(8'h00, 32'hFFFF_FFFD);
    doRead(8'h00, 32'hFFFF_FFFD, "R2");
    doRead(8'h00, 32'hFFFF_FFFE, "R2");
    doRead(8'h20, 32'h0, "R3");
    doRead(8'h20, 32'h4, "R3");
    doRead(8'h00, 32'h1, "R2");
    doWrite(8'h20, 32'h4);
    doRead(8'h20, 32'h0, "R8");

    // R7 one-shot timer 2, reload 12
    doWrite(8'h10, 32'h0000_000F);
    idle(11);
    checkIrq(2'b00, "R7");
    idle(1);
    checkIrq(2'b10, "R9");
    idle(5);
    doRead(8'h0C, 32'h0, "R7");
    doRead(8'h20, 32'h2, "R7");
    checkIrq(2'b10, "R9");
    doWrite(8'h20, 32'h2);
    checkIrq(2'b00, "R9");
    doWrite(8'h10, 32'h0);

    // R8 set on same edge as clear, write of 0 keeps bit
    doWrite(8'h08, 32'h0000_0005);
    idle(3);
    doWrite(8'h20, 32'h1);
    doRead(8'h20, 32'h1, "R8");
    doWrite(8'h20, 32'h0);
    doRead(8'h20, 32'h1, "R8");
    doWrite(8'h08, 32'h0);
    doWrite(8'h20, 32'h1);
    doRead(8'h20, 32'h0, "R8");

    // R4 restart and low-bit clearing
    doWrite(8'h08, 32'h0000_0021);
    doWrite(8'h08, 32'h0000_0013);
    doRead(8'h04, 32'h10, "R4");
    doWrite(8'h08, 32'h0000_0027);
    doRead(8'h04, 32'h24, "R4");
    doRead(8'h08, 32'h27, "R4");
    doWrite(8'h08, 32'h0);

    // R11 direct count load while disabled
    doWrite(8'h04, 32'h100);
    doRead(8'h04, 32'h100, "R11");
    idle(3);
    doRead(8'h04, 32'h100, "R5");

    finishRun();
  end
endmodule